// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block sits behind an 8-bit byte stream from a host bridge and turns it into register accesses on a small acquisition-control register file. Every command byte splits into two halves. The upper four bits select an operation, and the lower four bits carry a nibble of payload. The register address is built from two such commands. So is every write byte. A byte is written into the register file only when its upper nibble arrives.

Reads return one byte on a separate output stream that uses a valid/ready handshake. The stepping read moves the address forward after each byte, so a burst walks consecutive registers. The register file holds three groups of registers:

- A mode register, whose command values start capture, halt capture or switch to sample-memory readback.
- A read-only window that shows a 24-bit trigger position and a 24-bit stop position.
- A small bank of general read/write registers.

The positions come from outside the block as plain inputs.

Top module: `nibcmd_regs`

## Requirements
- R1: A synchronous reset clears the address, the pending low data nibble, the mode register, every general register and the two mode flags `acqRun` and `memRead`. After reset `rdValid` is 0 and `cmdReady` is 1.
- R2: Opcode 0x0 loads its payload into address bits [3:0]. Opcode 0x1 loads its payload into address bits [7:4]. A later read returns the register at the assembled address.
- R3: Opcode 0x2 only latches a low data nibble and changes no register. Opcode 0x3 writes the byte {its payload, latched low nibble} to the current address.
- R4: Several low/high data pairs may follow one address. Each completed pair writes the same address in turn, and the last one wins.
- R5: If an opcode 0x3 arrives with no opcode 0x2 since the last write, it writes {payload, 0x0}.
- R6: Opcode 0x4 returns exactly one byte, the register at the current address, and leaves the address unchanged.
- R7: Opcode 0x5 returns the register at the current address and then adds one to the address. Six of them starting at address 0x08 return trigger position bytes 0,1,2 and then stop position bytes 0,1,2, least significant byte first.
- R8: The mode register is at address 0x00 and reads back the last byte written to it.
  - Writing 0x0D sets `acqRun` and clears `memRead`.
  - Writing 0x11 clears `acqRun`.
  - Writing 0x02 sets `memRead` and clears `acqRun`.
  - Any other value leaves both flags unchanged.
- R9: While a read byte is pending (`rdValid` = 1), `cmdReady` is 0 and no command is taken. `rdData` holds steady until `rdReady` is seen.
- R10: Opcodes 0x6 to 0xF change no state and produce no read byte.
- R11: Writes to the position window (0x08 to 0x0D) or to an unmapped address change nothing. A read of an unmapped address returns 0x00. General registers sit at 0x10 to 0x17.
- R12: A stepping read at address 0xFF wraps the address to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command byte present |
| cmdData | input | 8 | Command byte: opcode [7:4], payload [3:0] |
| cmdReady | output | 1 | Block can take a command this cycle |
| rdValid | output | 1 | Read byte pending |
| rdReady | input | 1 | Consumer takes the pending read byte |
| rdData | output | 8 | Read byte |
| trigPos | input | 24 | Trigger position shown in the read-only window |
| stopPos | input | 24 | Stop position shown in the read-only window |
| acqRun | output | 1 | Capture running flag |
| memRead | output | 1 | Sample-memory readback flag |

## Verification
A command is taken on the rising edge where `cmdValid` and `cmdReady` are both high. Address, latch, register and mode-flag updates all land on that same edge. The read byte and `rdValid` appear one register stage later, that is, after the same edge. The bench drives and samples on falling edges only. It checks flags in the half cycle after the accepting edge and reads the byte at the first falling edge where `rdValid` is high. It then keeps `rdReady` high for exactly one rising edge. A stall test holds a read pending for several cycles while a write command waits at the input. It confirms that the data stays put and that the waiting write never lands.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] OP_ADDR_LO  = 4'h0;
  localparam logic [NIB_W-1:0] OP_ADDR_HI  = 4'h1;
  localparam logic [NIB_W-1:0] OP_DATA_LO  = 4'h2;
  localparam logic [NIB_W-1:0] OP_DATA_HI  = 4'h3;
  localparam logic [NIB_W-1:0] OP_READ     = 4'h4;
  localparam logic [NIB_W-1:0] OP_READ_INC = 4'h5;

  localparam logic [BYTE_W-1:0] MODE_RUN   = 8'h0D;
  localparam logic [BYTE_W-1:0] MODE_HALT  = 8'h11;
  localparam logic [BYTE_W-1:0] MODE_MEMRD = 8'h02;

  typedef struct packed {
    logic             addrLo;
    logic             addrHi;
    logic             dataLo;
    logic             dataHiWr;
    logic             readNow;
    logic             stepAddr;
    logic [NIB_W-1:0] nib;
  } strobes_t;

endpackage

// File: rtl/nibcmd_ctrl.sv
module nibcmd_ctrl
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [BYTE_W-1:0] cmdData,
  output logic              cmdReady,
  input  logic              rdReady,
  output logic              rdValid,
  output strobes_t          stb
);

  logic             rdValidQ;
  logic             take;
  logic [NIB_W-1:0] op;
  logic             isRead;

  assign cmdReady = !rdValidQ;
  assign take     = cmdValid && cmdReady;
  assign op       = cmdData[BYTE_W-1:NIB_W];
  assign isRead   = (op == OP_READ) || (op == OP_READ_INC);

  always_comb begin
    stb          = '0;
    stb.nib      = cmdData[NIB_W-1:0];
    stb.addrLo   = take && (op == OP_ADDR_LO);
    stb.addrHi   = take && (op == OP_ADDR_HI);
    stb.dataLo   = take && (op == OP_DATA_LO);
    stb.dataHiWr = take && (op == OP_DATA_HI);
    stb.readNow  = take && isRead;
    stb.stepAddr = take && (op == OP_READ_INC);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdValidQ <= 1'b0;
    else if (take && isRead)
      rdValidQ <= 1'b1;
    else if (rdReady)
      rdValidQ <= 1'b0;
  end

  assign rdValid = rdValidQ;

endmodule

// File: rtl/nibcmd_dpath.sv
module nibcmd_dpath
  import nibcmd_pkg::*;
#(
  parameter int MODE_ADDR = 0,
  parameter int POS_BASE  = 8,
  parameter int POS_W     = 24,
  parameter int GP_BASE   = 16,
  parameter int GP_COUNT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [POS_W-1:0]  trigPos,
  input  logic [POS_W-1:0]  stopPos,
  output logic [BYTE_W-1:0] rdData,
  output logic              acqRun,
  output logic              memRead
);

  localparam int POS_BYTES = POS_W / BYTE_W;
  localparam int WIN_BYTES = 2 * POS_BYTES;
  localparam logic [BYTE_W-1:0] MODE_A = BYTE_W'(MODE_ADDR);

  logic [BYTE_W-1:0] addrQ;
  logic [NIB_W-1:0]  lowNibQ;
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] modeQ;
  logic              acqRunQ, memReadQ;
  logic [BYTE_W-1:0] gpQ [GP_COUNT];
  logic [GP_COUNT-1:0] gpHit;
  logic [2*POS_W-1:0] winBytes;
  logic [BYTE_W-1:0] rdByte;
  logic [BYTE_W-1:0] rdDataQ;
  logic              modeHit;

  assign wrByte   = {stb.nib, lowNibQ};
  assign winBytes = {stopPos, trigPos};
  assign modeHit  = (addrQ == MODE_A);

  // address assembly and stepping
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
    end else begin
      if (stb.addrLo) addrQ[NIB_W-1:0]      <= stb.nib;
      if (stb.addrHi) addrQ[BYTE_W-1:NIB_W] <= stb.nib;
      if (stb.stepAddr) addrQ <= addrQ + 8'd1;
    end
  end

  // low data nibble; cleared by each write so a lone high nibble pairs with zero
  always_ff @(posedge clk) begin
    if (rst)
      lowNibQ <= '0;
    else if (stb.dataHiWr)
      lowNibQ <= '0;
    else if (stb.dataLo)
      lowNibQ <= stb.nib;
  end

  // mode register and its decoded flags
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= '0;
      acqRunQ  <= 1'b0;
      memReadQ <= 1'b0;
    end else if (stb.dataHiWr && modeHit) begin
      modeQ <= wrByte;
      unique case (wrByte)
        MODE_RUN: begin
          acqRunQ  <= 1'b1;
          memReadQ <= 1'b0;
        end
        MODE_HALT: acqRunQ <= 1'b0;
        MODE_MEMRD: begin
          memReadQ <= 1'b1;
          acqRunQ  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // general register bank
  genvar g;
  generate
    for (g = 0; g < GP_COUNT; g++) begin : g_hit
      assign gpHit[g] = (addrQ == BYTE_W'(GP_BASE + g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < GP_COUNT; i++) begin
      if (rst)
        gpQ[i] <= '0;
      else if (stb.dataHiWr && gpHit[i])
        gpQ[i] <= wrByte;
    end
  end

  // read selection
  always_comb begin
    rdByte = '0;
    if (modeHit) rdByte = modeQ;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (addrQ == BYTE_W'(POS_BASE + i)) rdByte = winBytes[BYTE_W*i +: BYTE_W];
    end
    for (int i = 0; i < GP_COUNT; i++) begin
      if (gpHit[i]) rdByte = gpQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdDataQ <= '0;
    else if (stb.readNow)
      rdDataQ <= rdByte;
  end

  assign rdData  = rdDataQ;
  assign acqRun  = acqRunQ;
  assign memRead = memReadQ;

endmodule

// File: rtl/nibcmd_regs.sv
module nibcmd_regs
  import nibcmd_pkg::*;
#(
  parameter int MODE_ADDR = 0,
  parameter int POS_BASE  = 8,
  parameter int POS_W     = 24,
  parameter int GP_BASE   = 16,
  parameter int GP_COUNT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [7:0]       cmdData,
  output logic             cmdReady,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [7:0]       rdData,
  input  logic [POS_W-1:0] trigPos,
  input  logic [POS_W-1:0] stopPos,
  output logic             acqRun,
  output logic             memRead
);

  strobes_t stb;

  nibcmd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdData  (cmdData),
    .cmdReady (cmdReady),
    .rdReady  (rdReady),
    .rdValid  (rdValid),
    .stb      (stb)
  );

  nibcmd_dpath #(
    .MODE_ADDR (MODE_ADDR),
    .POS_BASE  (POS_BASE),
    .POS_W     (POS_W),
    .GP_BASE   (GP_BASE),
    .GP_COUNT  (GP_COUNT)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .trigPos (trigPos),
    .stopPos (stopPos),
    .rdData  (rdData),
    .acqRun  (acqRun),
    .memRead (memRead)
  );

endmodule

// File: rtl/nibcmd_regs_chk.sv
module nibcmd_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmdValid,
  input logic [7:0] cmdData,
  input logic       cmdReady,
  input logic       rdValid,
  input logic       rdReady,
  input logic [7:0] rdData,
  input logic       acqRun,
  input logic       memRead
);

  logic       take;
  logic [3:0] op;
  logic       rdCmd;
  logic       modeWrCand;

  assign take       = cmdValid && cmdReady;
  assign op         = cmdData[7:4];
  assign rdCmd      = take && (op == 4'h4 || op == 4'h5);
  assign modeWrCand = take && (op == 4'h3) && (cmdData[3:0] == 4'h0);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rdValid && !acqRun && !memRead && cmdReady)); // R1
  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> !cmdReady); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData))); // R9
  AST_READ_RESP: assert property (@(posedge clk) disable iff (rst)
    rdCmd |=> rdValid); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!rdValid && !rdCmd) |=> !rdValid); // R10
  AST_RUN_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(acqRun) |-> $past(modeWrCand)); // R8
  AST_MEMRD_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(memRead) |-> $past(modeWrCand)); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(acqRun && memRead)); // R8

endmodule

bind nibcmd_regs nibcmd_regs_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmdValid (cmdValid),
  .cmdData  (cmdData),
  .cmdReady (cmdReady),
  .rdValid  (rdValid),
  .rdReady  (rdReady),
  .rdData   (rdData),
  .acqRun   (acqRun),
  .memRead  (memRead)
);

// File: tb/nibcmd_regs_tb.sv
module nibcmd_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;
  localparam logic [23:0] TRIG = 24'hA1B2C3;
  localparam logic [23:0] STOP = 24'h0D0E0F;

  // {command byte, expected read byte (used for opcodes 0x4/0x5)}
  localparam logic [15:0] VECS [NVEC] = '{
    16'h02_00, 16'h11_00,              // R2 address 0x12
    16'h25_00, 16'h40_00,              // R3 low nibble alone writes nothing
    16'h3A_00, 16'h40_A5,              // R3 commit 0xA5
    16'h21_00, 16'h37_00,              // R4 first pair 0x71
    16'h2F_00, 16'h30_00, 16'h40_0F,   // R4 second pair wins
    16'h39_00, 16'h40_90,              // R5 lone high nibble
    16'h40_90,                         // R6 address unchanged
    16'h6F_00, 16'hF3_00, 16'h40_90,   // R10 ignored opcodes
    16'h08_00, 16'h10_00,              // R7 address 0x08
    16'h50_C3, 16'h50_B2, 16'h50_A1,
    16'h50_0F, 16'h50_0E, 16'h50_0D,
    16'h40_00,                         // R11 unmapped 0x0E reads zero
    16'h08_00, 16'h10_00, 16'h21_00, 16'h32_00,
    16'h40_C3                          // R11 window write ignored
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic       cmdReady;
  logic       rdValid;
  logic       rdReady = 1'b0;
  logic [7:0] rdData;
  logic [23:0] trigPos = TRIG;
  logic [23:0] stopPos = STOP;
  logic       acqRun;
  logic       memRead;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibcmd_regs u_dut (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdData  (cmdData),
    .cmdReady (cmdReady),
    .rdValid  (rdValid),
    .rdReady  (rdReady),
    .rdData   (rdData),
    .trigPos  (trigPos),
    .stopPos  (stopPos),
    .acqRun   (acqRun),
    .memRead  (memRead)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1;
    cmdData  = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic getRead(output logic [7:0] d);
    while (!rdValid) @(negedge clk);
    d = rdData;
    rdReady = 1'b1;
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] op, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    sendCmd(op);
    getRead(d);
    check(tag, d, exp);
  endtask

  task automatic writeByte(input logic [7:0] b);
    sendCmd({4'h2, b[3:0]});
    sendCmd({4'h3, b[7:4]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdValid after reset", rdValid, 0);
    check("R1 cmdReady after reset", cmdReady, 1);
    check("R1 acqRun after reset", acqRun, 0);
    check("R1 memRead after reset", memRead, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c;
      c = VECS[i][15:8];
      if (c[7:4] == 4'h4 || c[7:4] == 4'h5) begin
        readCheck(c, VECS[i][7:0], $sformatf("R2-table vec%0d", i));
      end else begin
        sendCmd(c);
        check($sformatf("R10 no read byte vec%0d", i), rdValid, 0);
      end
    end

    // R8 mode register behaviour
    sendCmd(8'h00); sendCmd(8'h10);
    writeByte(8'h0D);
    check("R8 run sets acqRun", acqRun, 1);
    check("R8 run keeps memRead low", memRead, 0);
    writeByte(8'h11);
    check("R8 halt clears acqRun", acqRun, 0);
    writeByte(8'h02);
    check("R8 memrd sets memRead", memRead, 1);
    check("R8 memrd acqRun low", acqRun, 0);
    writeByte(8'h07);
    check("R8 other value keeps memRead", memRead, 1);
    readCheck(8'h40, 8'h07, "R8 mode readback");
    writeByte(8'h0D);
    check("R8 run clears memRead", memRead, 0);
    check("R8 run again acqRun", acqRun, 1);

    // R12 wrap: 0xFF unmapped, then 0x00 mode register
    sendCmd(8'h0F); sendCmd(8'h1F);
    readCheck(8'h50, 8'h00, "R12 read at 0xFF");
    readCheck(8'h40, 8'h0D, "R12 wrapped to mode register");

    // R9 stall: hold a read pending while a write waits
    sendCmd(8'h02); sendCmd(8'h11);
    writeByte(8'h3C);
    sendCmd(8'h40);
    check("R9 rdValid pending", rdValid, 1);
    check("R9 cmdReady low while pending", cmdReady, 0);
    cmdValid = 1'b1;
    cmdData  = 8'h3F;
    repeat (3) begin
      @(negedge clk);
      check("R9 data held", rdData, 8'h3C);
      check("R9 still pending", rdValid, 1);
    end
    cmdValid = 1'b0;
    begin
      logic [7:0] d;
      getRead(d);
      check("R9 stalled byte", d, 8'h3C);
    end
    readCheck(8'h40, 8'h3C, "R9 blocked write not taken");

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 acqRun cleared", acqRun, 0);
    check("R1 cmdReady after reset", cmdReady, 1);
    readCheck(8'h40, 8'h00, "R1 address and mode cleared");
    sendCmd(8'h02); sendCmd(8'h11);
    readCheck(8'h40, 8'h00, "R1 general register cleared");
    sendCmd(8'h33);
    readCheck(8'h40, 8'h30, "R1 low nibble latch cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule